// File: doc/BRIEF.md
# Write-Only Two-Wire Command Receiver

This block is a receive-only target on an I2C bus. It samples the raw SCL and SDA lines in the system clock domain, cleans them up, and finds the START and STOP conditions and the clock edges. It then collects one fixed-length write transaction. The transaction is an address byte followed by four data bytes. When STOP closes a complete transaction, the block hands the 32-bit result to a downstream command decoder.

The first data byte becomes the top byte of the command word. Its high nibble selects the function and its low nibble is the decimal exponent. The next three bytes fill in a 24-bit value, most significant byte first.

The block never sends data. It pulls SDA low only to acknowledge a byte. A bad transaction is thrown away and nothing is released. This covers a wrong address, a read request, a wrong byte count, a new START before STOP, and a STOP in the middle of a byte.

Top module: `i2c_cmd_target`

## Requirements
- R1: While reset is asserted and right after it is released, `sdaDriveLow` and `cmdValid` are 0 and `cmdWord` is all zeros.
- R2: The device address is 7'b1100000 plus the value on `addrSel` (0 to 3). An address byte is {address[6:0], R/W} with the address sent MSB first and R/W last. If the address matches and R/W = 0, the block drives `sdaDriveLow` high during the ninth SCL clock of that byte.
- R3: An address byte that does not match, or that has R/W = 1, is not acknowledged. No later byte of that transaction is acknowledged, no command is released, and `cmdWord` keeps its value.
- R4: In an addressed write, each of the first four data bytes is acknowledged in its ninth clock.
- R5: The four data bytes land in `cmdWord` MSB first. The first byte goes to bits 31:24: function select in 31:28 and the exponent in 27:24. The following bytes go to 23:16, then 15:8, then 7:0.
- R6: A command is released only when STOP follows the fourth data byte's acknowledge. `cmdValid` is then high for exactly one cycle. `cmdWord` takes its new value in that same cycle and changes at no other time.
- R7: A START that arrives before STOP discards the partial transaction without releasing it. The new START begins a fresh transaction, and that transaction can complete normally.
- R8: A STOP after fewer than four data bytes releases nothing. A fifth data byte is not acknowledged, and the transaction it belongs to is discarded.
- R9: A pulse on SCL that lasts a single system clock is ignored and does not disturb the transaction.
- R10: `sdaDriveLow` is never asserted during the eight data bits of a byte. It changes only while the filtered SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Raw serial clock line |
| sdaIn | input | 1 | Raw serial data line |
| addrSel | input | 2 | Address strap, added to the base address |
| sdaDriveLow | output | 1 | When 1, the open-drain pad pulls SDA low (acknowledge) |
| cmdValid | output | 1 | One-cycle pulse marking a released command |
| cmdWord | output | 32 | Last released command word |

## Verification
Some rules are checked by the assertions on every cycle. `cmdValid` is always a single-cycle pulse. `cmdWord` moves only together with that pulse, and only once five bytes have been counted. The acknowledge drive changes only while the cleaned SCL is low, and it never appears outside the byte slots that may be acknowledged.

Other behaviour can only be shown by the bench scenarios. These include the address and R/W decoding under different strap values, and the byte order inside the command word. They also include the discard paths: a restarted transaction, a short transaction, an overlong transaction, and a one-cycle SCL glitch in the middle of a byte.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_ACK,
    ST_SKIP
  } rxState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic clearXfer;
    logic shiftBit;
    logic takeByte;
    logic commitCmd;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_cmd_deglitch.sv
module i2c_cmd_deglitch #(
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic cleanOut
);

  logic [SYNC_STAGES-1:0] syncQ;
  logic [FILT_LEN-1:0]    histQ;
  logic                   syncOut;

  assign syncOut = syncQ[SYNC_STAGES-1];

  // bus lines idle high, so all stages reset to 1
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ    <= '1;
      histQ    <= '1;
      cleanOut <= 1'b1;
    end else begin
      syncQ <= {syncQ[SYNC_STAGES-2:0], rawIn};
      histQ <= {histQ[FILT_LEN-2:0], syncOut};
      if (&histQ)
        cleanOut <= 1'b1;
      else if (~|histQ)
        cleanOut <= 1'b0;
    end
  end

endmodule

// File: rtl/i2c_cmd_ctrl.sv
module i2c_cmd_ctrl
  import i2c_cmd_pkg::*;
#(
  parameter int XFER_BYTES = 5,
  parameter int CNT_W      = 4,
  parameter int IDX_W      = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclClean,
  input  logic             sdaClean,
  input  logic [CNT_W-1:0] bitCount,
  input  logic [IDX_W-1:0] byteIdx,
  input  logic             addrHit,
  output dpStrobe_t        strobe,
  output logic             sdaDriveLow
);

  rxState_t state, stateNext;
  logic sclQ, sdaQ;
  logic sclRise, sclFall, startSeen, stopSeen;
  logic byteFull, fewBits, countDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclQ  <= 1'b1;
      sdaQ  <= 1'b1;
      state <= ST_IDLE;
    end else begin
      sclQ  <= sclClean;
      sdaQ  <= sdaClean;
      state <= stateNext;
    end
  end

  assign sclRise   = sclClean & ~sclQ;
  assign sclFall   = ~sclClean & sclQ;
  assign startSeen = sclClean & sclQ & sdaQ & ~sdaClean;
  assign stopSeen  = sclClean & sclQ & ~sdaQ & sdaClean;

  assign byteFull  = (bitCount == CNT_W'(BYTE_W));
  assign fewBits   = (bitCount <= CNT_W'(1));
  assign countDone = (byteIdx == IDX_W'(XFER_BYTES));

  always_comb begin
    stateNext = state;
    strobe    = '0;
    if (startSeen) begin
      // any START, first or repeated, restarts collection
      stateNext        = ST_RECV;
      strobe.clearXfer = 1'b1;
    end else if (stopSeen) begin
      stateNext = ST_IDLE;
      if (state == ST_RECV && countDone && fewBits)
        strobe.commitCmd = 1'b1;
    end else begin
      case (state)
        ST_RECV: begin
          if (sclRise && !byteFull) begin
            strobe.shiftBit = 1'b1;
          end else if (sclFall && byteFull) begin
            if (byteIdx == '0) begin
              if (addrHit) begin
                strobe.takeByte = 1'b1;
                stateNext       = ST_ACK;
              end else begin
                stateNext = ST_SKIP;
              end
            end else if (!countDone) begin
              strobe.takeByte = 1'b1;
              stateNext       = ST_ACK;
            end else begin
              stateNext = ST_SKIP;
            end
          end
        end
        ST_ACK: begin
          if (sclFall)
            stateNext = ST_RECV;
        end
        ST_SKIP: stateNext = ST_SKIP;
        default: stateNext = ST_IDLE;
      endcase
    end
  end

  assign sdaDriveLow = (state == ST_ACK);

endmodule

// File: rtl/i2c_cmd_dpath.sv
module i2c_cmd_dpath
  import i2c_cmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'h60,
  parameter int STRAP_W    = 2,
  parameter int XFER_BYTES = 5,
  parameter int CNT_W      = 4,
  parameter int IDX_W      = 3,
  parameter int CMD_W      = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sdaClean,
  input  logic [STRAP_W-1:0] addrSel,
  input  dpStrobe_t          strobe,
  output logic [CNT_W-1:0]   bitCount,
  output logic [IDX_W-1:0]   byteIdx,
  output logic               addrHit,
  output logic               cmdValid,
  output logic [CMD_W-1:0]   cmdWord
);

  logic [BYTE_W-1:0] shiftQ;
  logic [CMD_W-1:0]  accumQ;
  logic [ADDR_W-1:0] ownAddr;

  assign ownAddr = ADDR_BASE + ADDR_W'(addrSel);
  assign addrHit = (shiftQ[BYTE_W-1:1] == ownAddr) && !shiftQ[0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftQ   <= '0;
      bitCount <= '0;
      byteIdx  <= '0;
      accumQ   <= '0;
    end else if (strobe.clearXfer) begin
      bitCount <= '0;
      byteIdx  <= '0;
      accumQ   <= '0;
    end else if (strobe.shiftBit) begin
      shiftQ   <= {shiftQ[BYTE_W-2:0], sdaClean};
      bitCount <= bitCount + 1'b1;
    end else if (strobe.takeByte) begin
      bitCount <= '0;
      byteIdx  <= byteIdx + 1'b1;
      if (byteIdx != '0)
        accumQ <= {accumQ[CMD_W-BYTE_W-1:0], shiftQ};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid <= 1'b0;
      cmdWord  <= '0;
    end else begin
      cmdValid <= strobe.commitCmd;
      if (strobe.commitCmd)
        cmdWord <= accumQ;
    end
  end

endmodule

// File: rtl/i2c_cmd_target.sv
module i2c_cmd_target
  import i2c_cmd_pkg::*;
#(
  parameter logic [ADDR_W-1:0] ADDR_BASE = 7'b1100000,
  parameter int STRAP_W     = 2,
  parameter int XFER_BYTES  = 5,
  parameter int SYNC_STAGES = 2,
  parameter int FILT_LEN    = 3,
  localparam int CMD_W      = (XFER_BYTES - 1) * BYTE_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  logic [STRAP_W-1:0] addrSel,
  output logic               sdaDriveLow,
  output logic               cmdValid,
  output logic [CMD_W-1:0]   cmdWord
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam int IDX_W = $clog2(XFER_BYTES + 1);

  logic [1:0]       rawLines, cleanLines;
  logic             sclClean, sdaClean, addrHit;
  logic [CNT_W-1:0] bitCount;
  logic [IDX_W-1:0] byteIdx;
  dpStrobe_t        strobe;

  assign rawLines = {sdaIn, sclIn};

  for (genvar g = 0; g < 2; g++) begin : g_line
    i2c_cmd_deglitch #(
      .SYNC_STAGES(SYNC_STAGES),
      .FILT_LEN   (FILT_LEN)
    ) u_flt (
      .clk     (clk),
      .rstN    (rstN),
      .rawIn   (rawLines[g]),
      .cleanOut(cleanLines[g])
    );
  end

  assign sclClean = cleanLines[0];
  assign sdaClean = cleanLines[1];

  i2c_cmd_ctrl #(
    .XFER_BYTES(XFER_BYTES),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sclClean   (sclClean),
    .sdaClean   (sdaClean),
    .bitCount   (bitCount),
    .byteIdx    (byteIdx),
    .addrHit    (addrHit),
    .strobe     (strobe),
    .sdaDriveLow(sdaDriveLow)
  );

  i2c_cmd_dpath #(
    .ADDR_BASE (ADDR_BASE),
    .STRAP_W   (STRAP_W),
    .XFER_BYTES(XFER_BYTES),
    .CNT_W     (CNT_W),
    .IDX_W     (IDX_W),
    .CMD_W     (CMD_W)
  ) u_dpath (
    .clk     (clk),
    .rstN    (rstN),
    .sdaClean(sdaClean),
    .addrSel (addrSel),
    .strobe  (strobe),
    .bitCount(bitCount),
    .byteIdx (byteIdx),
    .addrHit (addrHit),
    .cmdValid(cmdValid),
    .cmdWord (cmdWord)
  );

endmodule

// File: rtl/i2c_cmd_checker.sv
module i2c_cmd_checker #(
  parameter int XFER_BYTES = 5,
  parameter int IDX_W      = 3,
  parameter int CMD_W      = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             sclClean,
  input logic             sdaDriveLow,
  input logic             cmdValid,
  input logic [CMD_W-1:0] cmdWord,
  input logic [IDX_W-1:0] byteIdx
);

  AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |=> !cmdValid); // R6

  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cmdValid |-> $stable(cmdWord)); // R6

  AST_COMMIT_FULL: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> ($past(byteIdx) == IDX_W'(XFER_BYTES))); // R8

  AST_ACK_SCL_LOW: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaDriveLow) |-> !sclClean); // R10

  AST_ACK_SLOT: assert property (@(posedge clk) disable iff (!rstN)
    sdaDriveLow |-> (byteIdx != '0 && byteIdx <= IDX_W'(XFER_BYTES))); // R4

endmodule

bind i2c_cmd_target i2c_cmd_checker #(
  .XFER_BYTES(XFER_BYTES),
  .IDX_W     (IDX_W),
  .CMD_W     (CMD_W)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sclClean   (sclClean),
  .sdaDriveLow(sdaDriveLow),
  .cmdValid   (cmdValid),
  .cmdWord    (cmdWord),
  .byteIdx    (byteIdx)
);

// File: tb/i2c_cmd_target_test.sv
`timescale 1ns/1ps
module i2c_cmd_target_test;

  localparam int Q = 25;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        sclM = 1'b1;
  logic        sdaM = 1'b1;
  logic [1:0]  strap = 2'd0;
  logic        sdaDriveLow;
  logic        cmdValid;
  logic [31:0] cmdWord;
  logic        sdaLine;

  int testsRun = 0;
  int testsFailed = 0;
  logic [31:0] expQ[$];
  logic [31:0] lastWord = 32'h0;

  always #4 clk = ~clk;

  assign sdaLine = sdaM & ~sdaDriveLow;

  i2c_cmd_target uut (
    .clk        (clk),
    .rstN       (rstN),
    .sclIn      (sclM),
    .sdaIn      (sdaLine),
    .addrSel    (strap),
    .sdaDriveLow(sdaDriveLow),
    .cmdValid   (cmdValid),
    .cmdWord    (cmdWord)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s: %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor side of the scoreboard
  always @(negedge clk) begin
    if (rstN && cmdValid) begin
      if (expQ.size() == 0) begin
        check(1'b0, "R6", "unexpected command release", cmdWord, lastWord);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        check(cmdWord == e, "R5", "released command word", cmdWord, e);
      end
    end
  end

  task automatic startCond();
    wq(Q); sdaM = 1'b1; wq(Q); sclM = 1'b1; wq(Q); sdaM = 1'b0; wq(Q); sclM = 1'b0;
  endtask

  task automatic stopCond();
    wq(Q); sdaM = 1'b0; wq(Q); sclM = 1'b1; wq(Q); sdaM = 1'b1; wq(2 * Q);
  endtask

  task automatic sendByte(input logic [7:0] val, input bit expAck,
                          input int glitchAt, input string tag);
    for (int b = 7; b >= 0; b--) begin
      wq(Q);
      if (b == glitchAt) begin
        sclM = 1'b1; wq(1); sclM = 1'b0;
      end
      sdaM = val[b];
      wq(Q); sclM = 1'b1; wq(Q);
      check(sdaDriveLow == 1'b0, "R10", "pull-down during data bit",
            {31'd0, sdaDriveLow}, 32'd0);
      wq(Q); sclM = 1'b0;
    end
    wq(Q); sdaM = 1'b1; wq(Q); sclM = 1'b1; wq(Q);
    check(sdaDriveLow == expAck, tag, "acknowledge in ninth clock",
          {31'd0, sdaDriveLow}, {31'd0, expAck});
    wq(Q); sclM = 1'b0;
  endtask

  // driver side: expectations are pushed from the requirements
  task automatic xfer(input logic [7:0] addrByte, input logic [31:0] word,
                      input int nData, input bit sendStop, input int glitchAt,
                      input string addrTag, input string dataTag);
    bit addrOk;
    logic [7:0] b;
    logic [6:0] own;
    own = 7'b1100000 + {5'd0, strap};
    addrOk = (addrByte[7:1] == own) && !addrByte[0];
    startCond();
    sendByte(addrByte, addrOk, -1, addrTag);
    for (int i = 0; i < nData; i++) begin
      b = (i < 4) ? word[31 - 8 * i -: 8] : 8'hA5;
      sendByte(b, addrOk && (i < 4), (i == 0) ? glitchAt : -1,
               (i < 4) ? dataTag : "R8");
    end
    if (sendStop) begin
      if (addrOk && nData == 4) begin
        expQ.push_back(word);
        lastWord = word;
      end
      stopCond();
    end
  endtask

  initial begin
    wq(3);
    check(sdaDriveLow == 1'b0 && cmdValid == 1'b0 && cmdWord == 32'h0, "R1",
          "outputs in reset", cmdWord | {30'd0, sdaDriveLow, cmdValid}, 32'h0);
    rstN = 1'b1;
    wq(2);
    check(sdaDriveLow == 1'b0 && cmdValid == 1'b0 && cmdWord == 32'h0, "R1",
          "outputs after reset", cmdWord | {30'd0, sdaDriveLow, cmdValid}, 32'h0);

    // R2 R4 R5 R6: basic writes with strap 0
    xfer(8'hC0, 32'h130007D0, 4, 1'b1, -1, "R2", "R4");
    xfer(8'hC0, 32'h26ABCDEF, 4, 1'b1, -1, "R2", "R4");

    // R2: strap 2 moves the address to 1100010
    strap = 2'd2;
    xfer(8'hC4, 32'h50123456, 4, 1'b1, -1, "R2", "R4");

    // R3: old address no longer matches
    xfer(8'hC0, 32'h1F000001, 4, 1'b1, -1, "R3", "R3");
    wq(Q);
    check(cmdWord == lastWord, "R3", "word kept after wrong address", cmdWord, lastWord);

    // R3: read request to the own address
    xfer(8'hC5, 32'h2E000002, 4, 1'b1, -1, "R3", "R3");
    wq(Q);
    check(cmdWord == lastWord, "R3", "word kept after read request", cmdWord, lastWord);

    // R7: restart after two data bytes, then a complete write
    xfer(8'hC4, 32'h3C777777, 2, 1'b0, -1, "R7", "R7");
    xfer(8'hC4, 32'h41000A0B, 4, 1'b1, -1, "R7", "R7");

    // R8: short transaction
    xfer(8'hC4, 32'h44556677, 3, 1'b1, -1, "R8", "R8");
    wq(Q);
    check(cmdWord == lastWord, "R8", "word kept after short write", cmdWord, lastWord);

    // R8: five data bytes, last one refused
    xfer(8'hC4, 32'h388899AA, 5, 1'b1, -1, "R8", "R8");
    wq(Q);
    check(cmdWord == lastWord, "R8", "word kept after long write", cmdWord, lastWord);

    // R9: one-cycle SCL pulse in the middle of the first data byte
    strap = 2'd3;
    xfer(8'hC6, 32'h03FEDCBA, 4, 1'b1, 4, "R9", "R9");

    wq(4 * Q);
    check(expQ.size() == 0, "R6", "all expected commands released",
          expQ.size(), 32'd0);
    check(cmdWord == 32'h03FEDCBA, "R9", "final word after glitch", cmdWord, 32'h03FEDCBA);

    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    testsRun++;
    testsFailed++;
    $display("FAIL watchdog: all requirements actual=timeout expected=completion");
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule